// File: doc/BRIEF.md
# Descriptor Retire Tracker

The tracker follows a transmit descriptor ring from the consumer side. A DMA engine reports how far it has read through the ring as a head index. The tracker keeps its own copy of that head and walks it forward one ring slot per clock until the two agree. It counts every slot it retires. Whenever the walk passes the last descriptor of the oldest outstanding request, it reports that request as finished. Requests are recorded when the producer writes their descriptors. Each request is recorded as a tag plus a span of ring slots, and the spans are held in a short in-order queue.

Some descriptors belong to no tracked request, such as leading header slots. The tracker retires these without reporting anything. A flush drains the ring in three steps. It first retires up to the head the engine reported when the flush was requested. It then reports every request still queued as aborted, oldest first. Finally it resynchronises the counters and returns all ring indices to zero. A request submitted while the engine is stopped is not placed on the ring. Instead, it and everything queued ahead of it complete as aborted, in order.

Top module: `retire_tracker`

## Requirements
- R1: While the tracker is not busy and `head_idx` differs from `hw_head`, `head_idx` advances by exactly one slot per clock. After slot RING_DEPTH-1 it wraps to 0. It never holds a value of RING_DEPTH or above.
- R2: `removed_cnt` increases by one for each retired slot and never decreases. `free_cnt` always equals RING_DEPTH-1 minus the number of slots submitted but not yet retired.
- R3: An accepted live submission needs 1 <= `sub_total` <= RING_DEPTH-1 and `sub_lead` < `sub_total`. It records a tracked span that starts at tail+`sub_lead` and ends (exclusive) at tail+`sub_total`, both taken modulo RING_DEPTH. The tail then moves to the span end. `gen` increments modulo 2^GEN_W each time the tail wraps past slot RING_DEPTH-1.
- R4: When a retirement step moves the head onto the end index of the oldest queued live request, that request is removed from the queue. On the next clock its tag appears on `cmp_tag` with `cmp_valid`=1 and `cmp_abort`=0. Completions come out one per clock at most, in submission order.
- R5: Slots outside every tracked span, such as the `sub_lead` slots of a request, are retired and counted but produce no completion.
- R6: `progress` is high for one clock after each retirement step, together with the updated `free_cnt`.
- R7: A `flush_req` pulse, while not busy, captures `hw_head` and raises `busy`. The tracker then retires up to the captured index, reporting OK completions as in R4. Next it reports every remaining request with `cmp_abort`=1, oldest first. Finally it sets `removed_cnt` equal to the submitted total and returns `head_idx`, `tail_idx` and `gen` to 0 before dropping `busy`.
- R8: In the clock where `flush_req` is high, a simultaneous submission is ignored and no slot is retired.
- R9: A submission accepted while `engine_run` is low is queued without ring slots and leaves tail, `gen` and the counters unchanged. It raises `busy`, and every queued request, ending with the new one, then completes with `cmp_abort`=1 in queue order.
- R10: A submission is ignored while `busy` is high or while REQ_DEPTH requests are already queued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| hw_head | input | IDX_W | Ring slot the engine will read next |
| engine_run | input | 1 | Engine is running; low sends submissions down the abort path |
| flush_req | input | 1 | One-clock request to flush the ring |
| sub_valid | input | 1 | Submission strobe |
| sub_tag | input | TAG_W | Tag returned with the request's completion |
| sub_lead | input | IDX_W | Leading untracked slots of the request |
| sub_total | input | IDX_W | Total ring slots written for the request |
| busy | output | 1 | Drain or flush in progress; submissions are ignored |
| head_idx | output | IDX_W | Local head index |
| tail_idx | output | IDX_W | Local tail index |
| gen | output | GEN_W | Ring wrap generation count |
| removed_cnt | output | CNT_W | Retired slot counter |
| free_cnt | output | IDX_W+1 | Free ring slots |
| progress | output | 1 | Retirement happened on the previous clock |
| cmp_valid | output | 1 | Completion strobe |
| cmp_tag | output | TAG_W | Tag of the completed request |
| cmp_abort | output | 1 | 0: completed OK, 1: aborted |

## Verification
The bench builds the tracker with a 12-slot ring, which is not a power of two. This means the wrap at RING_DEPTH is tested separately from the natural 16-count rollover of a 4-bit index. A queue depth of 4 lets the bench reach the full-queue case within a few submissions. An 8-bit removed counter rolls over during the random phase, so R2 is checked across the counter wrap. The 2-bit generation counter also cycles through all its values.

// File: rtl/rtrk_pkg.sv
package rtrk_pkg;

  // Sequencing modes of the tracker.
  typedef enum logic [2:0] {
    MD_RUN   = 3'd0,  // normal retirement and submission
    MD_DRAIN = 3'd1,  // abort everything queued (engine stopped)
    MD_FRET  = 3'd2,  // flush: retire up to the captured head
    MD_FABT  = 3'd3,  // flush: abort what is left
    MD_FCLR  = 3'd4   // flush: resync counters and indices
  } mode_e;

  // Modular addition on a ring of arbitrary size (a, b < depth).
  function automatic logic [31:0] ring_add(input logic [31:0] a,
                                           input logic [31:0] b,
                                           input logic [31:0] depth);
    logic [32:0] s;
    s = {1'b0, a} + {1'b0, b};
    if (s >= {1'b0, depth}) s = s - {1'b0, depth};
    return s[31:0];
  endfunction

  // True when a + b passes the last slot of the ring.
  function automatic logic ring_wraps(input logic [31:0] a,
                                      input logic [31:0] b,
                                      input logic [31:0] depth);
    return ({1'b0, a} + {1'b0, b}) >= {1'b0, depth};
  endfunction

  // Membership of slot x in the circular half-open span [s, e).
  function automatic logic in_span(input logic [31:0] s,
                                   input logic [31:0] e,
                                   input logic [31:0] x);
    if (s == e)     return 1'b0;
    else if (s < e) return (x >= s) && (x < e);
    else            return (x >= s) || (x < e);
  endfunction

endpackage

// File: rtl/rtrk_req_fifo.sv
module rtrk_req_fifo #(
  parameter int unsigned SLOTS = 4,
  parameter int unsigned W     = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] wdata,
  input  logic         pop,
  output logic [W-1:0] rdata,
  output logic         empty,
  output logic         full
);
  localparam int unsigned PW   = (SLOTS > 1) ? $clog2(SLOTS) : 1;
  localparam int unsigned CW   = $clog2(SLOTS + 1);
  localparam bit          POW2 = ((SLOTS & (SLOTS - 1)) == 0);

  logic [W-1:0]  slot_q [SLOTS];
  logic [PW-1:0] wr_q, rd_q, wr_nxt, rd_nxt;
  logic [CW-1:0] cnt_q;
  logic          do_push, do_pop;

  assign empty   = (cnt_q == '0);
  assign full    = (cnt_q == CW'(SLOTS));
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign rdata   = slot_q[rd_q];

  // Pointer increment: free rollover for power-of-two depth, compare otherwise.
  generate
    if (POW2) begin : g_p2
      assign wr_nxt = wr_q + PW'(1);
      assign rd_nxt = rd_q + PW'(1);
    end else begin : g_np2
      assign wr_nxt = (wr_q == PW'(SLOTS - 1)) ? '0 : wr_q + PW'(1);
      assign rd_nxt = (rd_q == PW'(SLOTS - 1)) ? '0 : rd_q + PW'(1);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (do_push) slot_q[wr_q] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_push) wr_q <= wr_nxt;
      if (do_pop)  rd_q <= rd_nxt;
      case ({do_push, do_pop})
        2'b10:   cnt_q <= cnt_q + CW'(1);
        2'b01:   cnt_q <= cnt_q - CW'(1);
        default: cnt_q <= cnt_q;
      endcase
    end
  end

endmodule

// File: rtl/rtrk_walker.sv
module rtrk_walker
  import rtrk_pkg::*;
#(
  parameter int unsigned RING_DEPTH = 12,
  parameter int unsigned IDX_W      = 4,
  parameter int unsigned CNT_W      = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  input  logic             clear,
  input  logic [CNT_W-1:0] clear_removed,
  output logic [IDX_W-1:0] head,
  output logic [IDX_W-1:0] head_nxt,
  output logic [CNT_W-1:0] removed,
  output logic             progress
);
  // Slot the head lands on if this cycle retires one descriptor.
  assign head_nxt = IDX_W'(ring_add(32'(head), 32'd1, 32'(RING_DEPTH)));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head     <= '0;
      removed  <= '0;
      progress <= 1'b0;
    end else begin
      progress <= step;
      if (clear) begin
        head    <= '0;
        removed <= clear_removed;
      end else if (step) begin
        head    <= head_nxt;
        removed <= removed + CNT_W'(1);
      end
    end
  end

endmodule

// File: rtl/rtrk_tail.sv
module rtrk_tail
  import rtrk_pkg::*;
#(
  parameter int unsigned RING_DEPTH = 12,
  parameter int unsigned IDX_W      = 4,
  parameter int unsigned CNT_W      = 8,
  parameter int unsigned GEN_W      = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [IDX_W-1:0] lead,
  input  logic [IDX_W-1:0] total,
  input  logic             clear,
  output logic [IDX_W-1:0] tail,
  output logic [GEN_W-1:0] gen,
  output logic [CNT_W-1:0] added,
  output logic [IDX_W-1:0] ent_start,
  output logic [IDX_W-1:0] ent_end
);
  logic wraps;

  // Tracked span of the request being submitted: [tail+lead, tail+total).
  assign ent_start = IDX_W'(ring_add(32'(tail), 32'(lead), 32'(RING_DEPTH)));
  assign ent_end   = IDX_W'(ring_add(32'(tail), 32'(total), 32'(RING_DEPTH)));
  assign wraps     = ring_wraps(32'(tail), 32'(total), 32'(RING_DEPTH));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tail  <= '0;
      gen   <= '0;
      added <= '0;
    end else if (clear) begin
      tail <= '0;
      gen  <= '0;
    end else if (push) begin
      tail  <= ent_end;
      gen   <= gen + GEN_W'(wraps);
      added <= added + CNT_W'(total);
    end
  end

endmodule

// File: rtl/retire_tracker.sv
module retire_tracker
  import rtrk_pkg::*;
#(
  parameter int unsigned RING_DEPTH = 12,
  parameter int unsigned REQ_DEPTH  = 4,
  parameter int unsigned TAG_W      = 4,
  parameter int unsigned CNT_W      = 8,
  parameter int unsigned GEN_W      = 2,
  localparam int unsigned IDX_W     = $clog2(RING_DEPTH),
  localparam int unsigned FREE_W    = IDX_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  hw_head,
  input  logic              engine_run,
  input  logic              flush_req,
  input  logic              sub_valid,
  input  logic [TAG_W-1:0]  sub_tag,
  input  logic [IDX_W-1:0]  sub_lead,
  input  logic [IDX_W-1:0]  sub_total,
  output logic              busy,
  output logic [IDX_W-1:0]  head_idx,
  output logic [IDX_W-1:0]  tail_idx,
  output logic [GEN_W-1:0]  gen,
  output logic [CNT_W-1:0]  removed_cnt,
  output logic [FREE_W-1:0] free_cnt,
  output logic              progress,
  output logic              cmp_valid,
  output logic [TAG_W-1:0]  cmp_tag,
  output logic              cmp_abort
);
  // Queue entry: {live, tag, start, end}
  localparam int unsigned ENT_W = 1 + TAG_W + 2 * IDX_W;

  mode_e            mode_q, mode_d;
  logic [IDX_W-1:0] fl_tgt_q;
  logic [IDX_W-1:0] head_nxt;
  logic [IDX_W-1:0] ent_start, ent_end;
  logic [CNT_W-1:0] added_cnt, outstanding;
  logic [ENT_W-1:0] front, push_ent;
  logic             fifo_empty, fifo_full;

  // Named internal events (also observed by the checker).
  logic             step_w, pop_ok_w, pop_ab_w, clear_evt;
  logic             sub_acc, push_live, push_dead, flush_cap;
  logic             front_live;
  logic [TAG_W-1:0] front_tag;
  logic [IDX_W-1:0] front_start, front_end;

  assign front_live  = front[ENT_W-1];
  assign front_tag   = front[ENT_W-2 -: TAG_W];
  assign front_start = front[2*IDX_W-1 -: IDX_W];
  assign front_end   = front[IDX_W-1:0];

  // Retirement: normal walk toward the engine head, or flush walk toward
  // the captured head. A flush request blocks the walk in its own cycle.
  assign step_w = ((mode_q == MD_RUN) && !flush_req && (head_idx != hw_head)) ||
                  ((mode_q == MD_FRET) && (head_idx != fl_tgt_q));

  assign pop_ok_w  = step_w && !fifo_empty && front_live && (head_nxt == front_end);
  assign pop_ab_w  = ((mode_q == MD_DRAIN) || (mode_q == MD_FABT)) && !fifo_empty;
  assign clear_evt = (mode_q == MD_FCLR);

  assign sub_acc   = sub_valid && (mode_q == MD_RUN) && !flush_req && !fifo_full;
  assign push_live = sub_acc && engine_run;
  assign push_dead = sub_acc && !engine_run;
  assign flush_cap = flush_req && ((mode_q == MD_RUN) || (mode_q == MD_DRAIN));

  assign push_ent = push_live ? {1'b1, sub_tag, ent_start, ent_end}
                              : {1'b0, sub_tag, {IDX_W{1'b0}}, {IDX_W{1'b0}}};

  rtrk_req_fifo #(
    .SLOTS (REQ_DEPTH),
    .W     (ENT_W)
  ) u_fifo (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (sub_acc),
    .wdata (push_ent),
    .pop   (pop_ok_w || pop_ab_w),
    .rdata (front),
    .empty (fifo_empty),
    .full  (fifo_full)
  );

  rtrk_walker #(
    .RING_DEPTH (RING_DEPTH),
    .IDX_W      (IDX_W),
    .CNT_W      (CNT_W)
  ) u_walker (
    .clk           (clk),
    .rst_n         (rst_n),
    .step          (step_w),
    .clear         (clear_evt),
    .clear_removed (added_cnt),
    .head          (head_idx),
    .head_nxt      (head_nxt),
    .removed       (removed_cnt),
    .progress      (progress)
  );

  rtrk_tail #(
    .RING_DEPTH (RING_DEPTH),
    .IDX_W      (IDX_W),
    .CNT_W      (CNT_W),
    .GEN_W      (GEN_W)
  ) u_tail (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (push_live),
    .lead      (sub_lead),
    .total     (sub_total),
    .clear     (clear_evt),
    .tail      (tail_idx),
    .gen       (gen),
    .added     (added_cnt),
    .ent_start (ent_start),
    .ent_end   (ent_end)
  );

  // Free slots: one slot stays empty so full and empty rings differ.
  assign outstanding = added_cnt - removed_cnt;
  assign free_cnt    = FREE_W'(RING_DEPTH - 1) - FREE_W'(outstanding);
  assign busy        = (mode_q != MD_RUN);

  always_comb begin
    mode_d = mode_q;
    unique case (mode_q)
      MD_RUN: begin
        if (flush_req)      mode_d = MD_FRET;
        else if (push_dead) mode_d = MD_DRAIN;
      end
      MD_DRAIN: begin
        if (flush_req)       mode_d = MD_FRET;
        else if (fifo_empty) mode_d = MD_RUN;
      end
      MD_FRET: if (head_idx == fl_tgt_q) mode_d = MD_FABT;
      MD_FABT: if (fifo_empty) mode_d = MD_FCLR;
      MD_FCLR: mode_d = MD_RUN;
      default: mode_d = MD_RUN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q    <= MD_RUN;
      fl_tgt_q  <= '0;
      cmp_valid <= 1'b0;
      cmp_tag   <= '0;
      cmp_abort <= 1'b0;
    end else begin
      mode_q    <= mode_d;
      if (flush_cap) fl_tgt_q <= hw_head;
      cmp_valid <= pop_ok_w || pop_ab_w;
      cmp_tag   <= front_tag;
      cmp_abort <= pop_ab_w;
    end
  end

endmodule

// File: rtl/retire_tracker_chk.sv
module retire_tracker_chk
  import rtrk_pkg::*;
#(
  parameter int unsigned RING_DEPTH = 12,
  parameter int unsigned IDX_W      = 4,
  parameter int unsigned CNT_W      = 8,
  parameter int unsigned GEN_W      = 2,
  parameter int unsigned FREE_W     = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              flush_req,
  input logic              busy,
  input logic [IDX_W-1:0]  head_idx,
  input logic [IDX_W-1:0]  tail_idx,
  input logic [GEN_W-1:0]  gen,
  input logic [CNT_W-1:0]  removed_cnt,
  input logic [CNT_W-1:0]  added_cnt,
  input logic [FREE_W-1:0] free_cnt,
  input logic              progress,
  input logic              cmp_valid,
  input logic              cmp_abort,
  input logic              pop_ok,
  input logic              front_start_live,
  input logic [IDX_W-1:0]  front_start,
  input logic [IDX_W-1:0]  front_end,
  input logic              clear_evt
);

  assert_head_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (head_idx != $past(head_idx)) |->
      ((head_idx == IDX_W'(ring_add(32'($past(head_idx)), 32'd1, 32'(RING_DEPTH)))) ||
       (head_idx == '0)))
    else $error("head moved by more than one slot");

  assert_head_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
    32'(head_idx) < RING_DEPTH)
    else $error("head outside ring");

  assert_removed_mono_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(clear_evt) |-> (CNT_W'(removed_cnt - $past(removed_cnt)) <= CNT_W'(1)))
    else $error("removed counter jumped or decreased");

  assert_free_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    32'(free_cnt) <= RING_DEPTH - 1)
    else $error("free count above ring capacity");

  assert_ok_in_span_R4: assert property (@(posedge clk) disable iff (!rst_n)
    pop_ok |-> (front_start_live &&
                in_span(32'(front_start), 32'(front_end), 32'(head_idx))))
    else $error("OK completion outside the request span");

  assert_progress_moves_R6: assert property (@(posedge clk) disable iff (!rst_n)
    progress |-> (head_idx != $past(head_idx)))
    else $error("progress without a retired slot");

  assert_flush_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $past(clear_evt) |-> ((head_idx == '0) && (tail_idx == '0) && (gen == '0) &&
                          (removed_cnt == added_cnt)))
    else $error("flush did not resync ring state");

  assert_flush_prio_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (flush_req && !busy) |=> ((tail_idx == $past(tail_idx)) && (head_idx == $past(head_idx))))
    else $error("work done in the flush request cycle");

  assert_abort_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_valid && cmp_abort) |-> busy)
    else $error("abort completion outside drain or flush");

endmodule

bind retire_tracker retire_tracker_chk #(
  .RING_DEPTH (RING_DEPTH),
  .IDX_W      (IDX_W),
  .CNT_W      (CNT_W),
  .GEN_W      (GEN_W),
  .FREE_W     (FREE_W)
) u_chk (
  .clk              (clk),
  .rst_n            (rst_n),
  .flush_req        (flush_req),
  .busy             (busy),
  .head_idx         (head_idx),
  .tail_idx         (tail_idx),
  .gen              (gen),
  .removed_cnt      (removed_cnt),
  .added_cnt        (added_cnt),
  .free_cnt         (free_cnt),
  .progress         (progress),
  .cmp_valid        (cmp_valid),
  .cmp_abort        (cmp_abort),
  .pop_ok           (pop_ok_w),
  .front_start_live (front_live),
  .front_start      (front_start),
  .front_end        (front_end),
  .clear_evt        (clear_evt)
);

// File: tb/test_retire_tracker.sv
module test_retire_tracker;
  localparam int D  = 12;
  localparam int QD = 4;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [3:0] hw_head;
  logic       engine_run, flush_req, sub_valid;
  logic [3:0] sub_tag, sub_lead, sub_total;
  logic       busy, progress, cmp_valid, cmp_abort;
  logic [3:0] head_idx, tail_idx, cmp_tag;
  logic [1:0] gen;
  logic [7:0] removed_cnt;
  logic [4:0] free_cnt;

  always #10 clk = ~clk;  // 50 MHz

  retire_tracker i_retire_tracker (
    .clk(clk), .rst_n(rst_n), .hw_head(hw_head), .engine_run(engine_run),
    .flush_req(flush_req), .sub_valid(sub_valid), .sub_tag(sub_tag),
    .sub_lead(sub_lead), .sub_total(sub_total), .busy(busy),
    .head_idx(head_idx), .tail_idx(tail_idx), .gen(gen),
    .removed_cnt(removed_cnt), .free_cnt(free_cnt), .progress(progress),
    .cmp_valid(cmp_valid), .cmp_tag(cmp_tag), .cmp_abort(cmp_abort)
  );

  int nchk = 0, nfail = 0, ncmp = 0, nprog = 0;
  int mq_tag[$];
  int mq_end[$];
  int eq_tag[$];
  int eq_ab[$];
  int mhead = 0, mtail = 0, mgen = 0, madded = 0, mremoved = 0, prog_exp = 0;
  bit finished = 1'b0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Completion and progress monitor, sampling on the falling edge.
  always @(negedge clk) begin
    if (rst_n) begin
      if (cmp_valid) begin
        ncmp++;
        if (eq_tag.size() == 0) begin
          chk(1'b0, "R4", "unexpected completion tag", int'(cmp_tag), -1);
        end else begin
          chk(int'(cmp_tag) == eq_tag[0], "R4", "completion tag order", int'(cmp_tag), eq_tag[0]);
          chk(int'(cmp_abort) == eq_ab[0], "R7", "completion status", int'(cmp_abort), eq_ab[0]);
          void'(eq_tag.pop_front());
          void'(eq_ab.pop_front());
        end
      end
      if (progress) nprog++;
    end
  end

  task automatic tick();
    @(negedge clk);
    #1;
  endtask

  // Reference retirement walk (R1, R2, R4, R5, R6).
  task automatic model_walk(input int tgt);
    while (mhead != tgt) begin
      mhead = (mhead + 1) % D;
      mremoved++;
      prog_exp++;
      if (mq_end.size() > 0 && mq_end[0] == mhead) begin
        eq_tag.push_back(mq_tag[0]);
        eq_ab.push_back(0);
        void'(mq_tag.pop_front());
        void'(mq_end.pop_front());
      end
    end
  endtask

  task automatic model_abort_all();
    while (mq_tag.size() > 0) begin
      eq_tag.push_back(mq_tag[0]);
      eq_ab.push_back(1);
      void'(mq_tag.pop_front());
      void'(mq_end.pop_front());
    end
  endtask

  task automatic settle(input string req);
    int n;
    n = 0;
    while ((int'(head_idx) != mhead || busy || eq_tag.size() != 0) && n < 100) begin
      tick();
      n++;
    end
    chk(n < 100, req, "settle timeout cycles", n, 0);
    chk(int'(head_idx) == mhead, "R1", "head index", int'(head_idx), mhead);
    chk(int'(tail_idx) == mtail, "R3", "tail index", int'(tail_idx), mtail);
    chk(int'(gen) == mgen, "R3", "generation", int'(gen), mgen);
    chk(int'(removed_cnt) == (mremoved & 255), "R2", "removed count", int'(removed_cnt), mremoved & 255);
    chk(int'(free_cnt) == D - 1 - (madded - mremoved), "R2", "free count",
        int'(free_cnt), D - 1 - (madded - mremoved));
    chk(nprog == prog_exp, "R6", "progress pulses", nprog, prog_exp);
  endtask

  task automatic submit(input int tag, input int lead, input int total, input bit run);
    sub_valid  = 1'b1;
    sub_tag    = 4'(tag);
    sub_lead   = 4'(lead);
    sub_total  = 4'(total);
    engine_run = run;
    tick();
    sub_valid  = 1'b0;
    engine_run = 1'b1;
    if (run) begin
      mq_tag.push_back(tag);
      mq_end.push_back((mtail + total) % D);
      if (mtail + total >= D) mgen = (mgen + 1) % 4;
      mtail  = (mtail + total) % D;
      madded += total;
    end else begin
      // R9: everything queued, then the new request, aborts in order
      model_abort_all();
      eq_tag.push_back(tag);
      eq_ab.push_back(1);
    end
  endtask

  // Submission that must be ignored (R10); the model is left unchanged.
  task automatic try_ignored(input int tag, input int total);
    sub_valid  = 1'b1;
    sub_tag    = 4'(tag);
    sub_lead   = 4'd0;
    sub_total  = 4'(total);
    engine_run = 1'b1;
    tick();
    sub_valid  = 1'b0;
  endtask

  task automatic advance(input int r);
    int tgt;
    tgt = (mhead + r) % D;
    model_walk(tgt);
    hw_head = 4'(tgt);
    settle("R1");
  endtask

  task automatic flush(input int r, input bit with_sub);
    int tgt;
    tgt = (mhead + r) % D;
    hw_head   = 4'(tgt);
    flush_req = 1'b1;
    if (with_sub) begin  // R8: must be ignored, tag 15 never completes
      sub_valid = 1'b1;
      sub_tag   = 4'd15;
      sub_lead  = 4'd0;
      sub_total = 4'd1;
    end
    tick();
    flush_req = 1'b0;
    sub_valid = 1'b0;
    hw_head   = 4'd0;
    chk(busy, "R7", "busy after flush request", int'(busy), 1);
    chk(int'(tail_idx) == mtail, "R8", "tail unchanged in flush cycle", int'(tail_idx), mtail);
    model_walk(tgt);
    model_abort_all();
    mremoved = madded;
    mhead = 0;
    mtail = 0;
    mgen  = 0;
    settle("R7");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      nchk++;
      nfail++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
    end
  end

  initial begin
    int c0, sel, outst, tot;
    void'($urandom(32'd7391));
    rst_n = 1'b0; hw_head = '0; engine_run = 1'b1; flush_req = 1'b0;
    sub_valid = 1'b0; sub_tag = '0; sub_lead = '0; sub_total = '0;
    repeat (4) tick();
    rst_n = 1'b1;
    tick();

    // Reset state
    chk(head_idx == 4'd0, "R1", "reset head", int'(head_idx), 0);
    chk(tail_idx == 4'd0, "R3", "reset tail", int'(tail_idx), 0);
    chk(removed_cnt == 8'd0, "R2", "reset removed", int'(removed_cnt), 0);
    chk(free_cnt == 5'(D - 1), "R2", "reset free", int'(free_cnt), D - 1);
    chk(!busy && !cmp_valid && !progress, "R10", "reset idle outputs", int'(busy), 0);

    // R5: leading slots retire silently, the span end completes
    submit(1, 2, 3, 1);
    settle("R3");
    c0 = ncmp;
    advance(2);
    chk(ncmp == c0, "R5", "no completion for lead slots", ncmp, c0);
    advance(1);
    chk(ncmp == c0 + 1, "R4", "one completion at span end", ncmp, c0 + 1);

    // R10: full queue ignores a fifth request
    for (int i = 0; i < QD; i++) submit(2 + i, 0, 2, 1);
    settle("R3");
    try_ignored(6, 2);
    settle("R10");
    advance(8);

    // R9: stopped engine aborts queue in order; R10 busy ignore
    submit(7, 0, 2, 1);
    submit(8, 1, 3, 1);
    submit(9, 0, 1, 0);
    chk(busy, "R9", "busy during abort drain", int'(busy), 1);
    try_ignored(10, 1);
    settle("R9");
    advance(5);

    // R7/R8: flush with requests straddling the captured head
    submit(11, 0, 3, 1);
    submit(12, 1, 4, 1);
    submit(13, 0, 2, 1);
    settle("R3");
    flush(5, 1'b1);

    // Random phase
    for (int it = 0; it < 400; it++) begin
      sel   = $urandom_range(0, 19);
      outst = madded - mremoved;
      if (sel < 8) begin
        tot = $urandom_range(1, 4);
        if (mq_tag.size() < QD && outst + tot <= D - 1) begin
          submit($urandom_range(0, 14), $urandom_range(0, tot - 1), tot, 1'b1);
          settle("R3");
        end else begin
          advance($urandom_range(0, outst));
        end
      end else if (sel < 17) begin
        advance($urandom_range(0, outst));
      end else if (sel == 17) begin
        if (mq_tag.size() < QD) begin
          submit($urandom_range(0, 14), 0, 1, 1'b0);
          settle("R9");
        end
      end else begin
        flush($urandom_range(0, outst), 1'($urandom_range(0, 1)));
      end
    end

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

endmodule